// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces every pixel-rate control signal that an interline CCD sensor needs during one horizontal line. It runs from a master clock that is several times faster than the pixel rate. It divides each pixel period into equal sub-phases and steps a pixel counter through a fixed line of 1848 pixel periods. In each sub-phase it drives the two complementary horizontal shift clocks, a reset-gate pulse and the two correlated-double-sampling strobes.

While the pixel counter sweeps the line, the block reports where it is. A region code and four one-hot flags mark the dummy stage, the optical-black pixels on either side and the effective pixels. Downstream logic can use them to clamp the black level on the optical-black pixels. Once the last optical-black pixel has left the horizontal register, the block holds the shift clocks still. It then opens a window for vertical-register transfer and, when software asks for it, a substrate charge-drain pulse for the electronic shutter. The drain request and its width are captured once per line, at line start.

All outputs come from one register stage. An output therefore shows the decode of the position the counters held just before the clock edge.

Top module: `ccdh_line_timing`

## Requirements
- R1: A line lasts LINE_PIX (1848) pixel periods of PHASES (4) master clocks each. `line_start` is high for exactly the first master clock of each line. The first clock edge after reset is released shows line position 0.
- R2: Pixels 0..27 are dummy (region 0, `is_dummy`). Pixels 28..31 are front optical black (region 1, `is_ob`). Pixels 32..1667 are effective (region 2, `is_active`). Pixels 1668..1715 are rear optical black (region 3, `is_ob`). Pixels 1716..1847 are blanking (region 4, `is_blank`). Exactly one flag is high at any time.
- R3: Outside blanking, `hclk_a` is high in sub-phases 0 and 1 of each pixel and low in sub-phases 2 and 3, and `hclk_b` is always its complement. During blanking `hclk_a` is held high and `hclk_b` low.
- R4: Outside blanking, `rst_gate` is high in sub-phase 0, `cds_ref` in sub-phase 1 and `cds_sig` in the last sub-phase (3). During blanking all three stay low.
- R5: `vt_win` is high for the whole of pixels 1720..1815 (blanking offset 4, length 96) and low everywhere else.
- R6: When `shutter_req` is high at line start, `shutter_drain` is high from pixel 1824 (blanking offset 108) for `shutter_width` pixels taken from the same clock edge. The pulse is cut off at the end of the line, and a width of 0 gives no pulse. When `shutter_req` is low at line start, the line has no pulse.
- R7: A change of `shutter_req` or `shutter_width` after line start has no effect on that line's drain pulse.
- R8: While `rst` is high, every clock edge sets the outputs to idle: `hclk_a`=1, `hclk_b`=0, region 4 with `is_blank` only, and every other output 0. The counters return to line position 0, and the captured drain request is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, PHASES per pixel period |
| rst | input | 1 | Synchronous active-high reset |
| shutter_req | input | 1 | Drain request, captured at line start |
| shutter_width | input | WIDTH_W | Drain width in pixel periods, captured at line start |
| line_start | output | 1 | One-clock pulse at the first master clock of a line |
| hclk_a | output | 1 | First horizontal shift clock phase |
| hclk_b | output | 1 | Second horizontal shift clock phase, complement of `hclk_a` |
| rst_gate | output | 1 | Reset-gate pulse, sub-phase 0 |
| cds_ref | output | 1 | Reset-level sample strobe, sub-phase 1 |
| cds_sig | output | 1 | Data-level sample strobe, last sub-phase |
| region | output | 3 | Region code 0..4 |
| is_dummy | output | 1 | Dummy-stage flag |
| is_ob | output | 1 | Optical-black flag, front or rear |
| is_active | output | 1 | Effective-pixel flag |
| is_blank | output | 1 | Blanking flag |
| vt_win | output | 1 | Vertical-transfer window |
| shutter_drain | output | 1 | Substrate charge-drain pulse |

## Verification
A reference model predicts every output for every master clock over several whole lines, so each region boundary and each sub-phase of each pixel is compared. The drain input is driven in several patterns, and each one separates a different fault:
- A normal width shows whether the start pixel and the length are right.
- A width of 40 runs past the end of the line and shows whether the pulse is cut off there.
- A width of 0 with the request held high shows whether the request and the width are gated correctly.
- Dropping the request just after line start tells capture at line start apart from live sampling.

A reset asserted in the middle of a drain pulse shows that the outputs go idle at once and that the line restarts from position 0.

// File: rtl/ccdh_pkg.sv
package ccdh_pkg;

    typedef enum logic [2:0] {
        RGN_DUMMY = 3'd0,
        RGN_OBF   = 3'd1,
        RGN_ACT   = 3'd2,
        RGN_OBR   = 3'd3,
        RGN_BLANK = 3'd4
    } region_e;

    typedef struct packed {
        logic hclk_a;
        logic hclk_b;
        logic rst_gate;
        logic cds_ref;
        logic cds_sig;
    } pix_strobe_t;

    typedef struct packed {
        logic dummy;
        logic ob;
        logic active;
        logic blank;
    } region_flags_t;

    typedef struct packed {
        logic          line_start;
        pix_strobe_t   strb;
        region_e       rgn;
        region_flags_t flg;
        logic          vt;
        logic          drain;
    } line_out_t;

    function automatic region_flags_t flags_of(region_e r);
        region_flags_t f;
        f.dummy  = (r == RGN_DUMMY);
        f.ob     = (r == RGN_OBF) || (r == RGN_OBR);
        f.active = (r == RGN_ACT);
        f.blank  = (r == RGN_BLANK);
        return f;
    endfunction

    function automatic line_out_t idle_out();
        line_out_t o;
        o.line_start    = 1'b0;
        o.strb.hclk_a   = 1'b1;
        o.strb.hclk_b   = 1'b0;
        o.strb.rst_gate = 1'b0;
        o.strb.cds_ref  = 1'b0;
        o.strb.cds_sig  = 1'b0;
        o.rgn           = RGN_BLANK;
        o.flg           = flags_of(RGN_BLANK);
        o.vt            = 1'b0;
        o.drain         = 1'b0;
        return o;
    endfunction

endpackage

// File: rtl/ccdh_counter.sv
module ccdh_counter #(
    parameter int PHASES   = 4,
    parameter int LINE_PIX = 1848,
    localparam int PH_W    = $clog2(PHASES),
    localparam int PIX_W   = $clog2(LINE_PIX)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PH_W-1:0]  phase,
    output logic [PIX_W-1:0] pix,
    output logic             at_start
);

    localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(PHASES - 1);
    localparam logic [PIX_W-1:0] PIX_LAST = PIX_W'(LINE_PIX - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= '0;
            pix   <= '0;
        end else if (phase == PH_LAST) begin
            phase <= '0;
            pix   <= (pix == PIX_LAST) ? '0 : pix + 1'b1;
        end else begin
            phase <= phase + 1'b1;
        end
    end

    assign at_start = (phase == '0) && (pix == '0);

endmodule

// File: rtl/ccdh_region_dec.sv
module ccdh_region_dec
    import ccdh_pkg::*;
#(
    parameter int DUMMY_PIX = 28,
    parameter int OBF_PIX   = 4,
    parameter int ACT_PIX   = 1636,
    parameter int OBR_PIX   = 48,
    parameter int PIX_W     = 11
) (
    input  logic [PIX_W-1:0] pix,
    output region_e          rgn,
    output region_flags_t    flg
);

    localparam logic [PIX_W-1:0] B_OBF   = PIX_W'(DUMMY_PIX);
    localparam logic [PIX_W-1:0] B_ACT   = PIX_W'(DUMMY_PIX + OBF_PIX);
    localparam logic [PIX_W-1:0] B_OBR   = PIX_W'(DUMMY_PIX + OBF_PIX + ACT_PIX);
    localparam logic [PIX_W-1:0] B_BLANK = PIX_W'(DUMMY_PIX + OBF_PIX + ACT_PIX + OBR_PIX);

    always_comb begin
        if (pix < B_OBF)        rgn = RGN_DUMMY;
        else if (pix < B_ACT)   rgn = RGN_OBF;
        else if (pix < B_OBR)   rgn = RGN_ACT;
        else if (pix < B_BLANK) rgn = RGN_OBR;
        else                    rgn = RGN_BLANK;
    end

    assign flg = flags_of(rgn);

endmodule

// File: rtl/ccdh_pixel_strobes.sv
module ccdh_pixel_strobes
    import ccdh_pkg::*;
#(
    parameter int PHASES = 4,
    localparam int PH_W  = $clog2(PHASES)
) (
    input  logic [PH_W-1:0] phase,
    input  logic            blank,
    output pix_strobe_t     strb
);

    localparam logic [PH_W-1:0] PH_HALF = PH_W'(PHASES / 2);
    localparam logic [PH_W-1:0] PH_REF  = PH_W'(1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PHASES - 1);

    always_comb begin
        strb.hclk_a   = blank ? 1'b1 : (phase < PH_HALF);
        strb.hclk_b   = ~strb.hclk_a;
        strb.rst_gate = !blank && (phase == '0);
        strb.cds_ref  = !blank && (phase == PH_REF);
        strb.cds_sig  = !blank && (phase == PH_LAST);
    end

endmodule

// File: rtl/ccdh_blank_windows.sv
module ccdh_blank_windows #(
    parameter int BLANK_START = 1716,
    parameter int LINE_PIX    = 1848,
    parameter int VT_OFS      = 4,
    parameter int VT_PIX      = 96,
    parameter int DRAIN_OFS   = 108,
    parameter int WIDTH_W     = 8,
    parameter int PIX_W       = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PIX_W-1:0]   pix,
    input  logic               at_start,
    input  logic               shutter_req,
    input  logic [WIDTH_W-1:0] shutter_width,
    output logic               vt,
    output logic               drain
);

    localparam int SUM_W = PIX_W + 1;
    localparam logic [PIX_W-1:0] VT_LO = PIX_W'(BLANK_START + VT_OFS);
    localparam logic [PIX_W-1:0] VT_HI = PIX_W'(BLANK_START + VT_OFS + VT_PIX);
    localparam logic [SUM_W-1:0] DR_LO = SUM_W'(BLANK_START + DRAIN_OFS);

    generate
        if (VT_OFS + VT_PIX > LINE_PIX - BLANK_START) begin : g_bad_vt
            $error("vertical transfer window exceeds blanking");
        end
        if (DRAIN_OFS >= LINE_PIX - BLANK_START) begin : g_bad_drain
            $error("drain start lies outside blanking");
        end
        if (WIDTH_W > PIX_W) begin : g_bad_width
            $error("drain width field wider than pixel counter");
        end
    endgenerate

    logic               armed;
    logic [WIDTH_W-1:0] width_q;
    logic [SUM_W-1:0]   dr_hi;
    logic [SUM_W-1:0]   pix_x;

    always_ff @(posedge clk) begin
        if (rst) begin
            armed   <= 1'b0;
            width_q <= '0;
        end else if (at_start) begin
            armed   <= shutter_req;
            width_q <= shutter_width;
        end
    end

    assign pix_x = {1'b0, pix};
    assign dr_hi = DR_LO + SUM_W'(width_q);
    assign vt    = (pix >= VT_LO) && (pix < VT_HI);
    assign drain = armed && (pix_x >= DR_LO) && (pix_x < dr_hi);

endmodule

// File: rtl/ccdh_line_timing.sv
module ccdh_line_timing
    import ccdh_pkg::*;
#(
    parameter int PHASES    = 4,
    parameter int DUMMY_PIX = 28,
    parameter int OBF_PIX   = 4,
    parameter int ACT_PIX   = 1636,
    parameter int OBR_PIX   = 48,
    parameter int LINE_PIX  = 1848,
    parameter int VT_OFS    = 4,
    parameter int VT_PIX    = 96,
    parameter int DRAIN_OFS = 108,
    parameter int WIDTH_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               shutter_req,
    input  logic [WIDTH_W-1:0] shutter_width,
    output logic               line_start,
    output logic               hclk_a,
    output logic               hclk_b,
    output logic               rst_gate,
    output logic               cds_ref,
    output logic               cds_sig,
    output logic [2:0]         region,
    output logic               is_dummy,
    output logic               is_ob,
    output logic               is_active,
    output logic               is_blank,
    output logic               vt_win,
    output logic               shutter_drain
);

    localparam int PH_W        = $clog2(PHASES);
    localparam int PIX_W       = $clog2(LINE_PIX);
    localparam int BLANK_START = DUMMY_PIX + OBF_PIX + ACT_PIX + OBR_PIX;

    generate
        if (PHASES < 4) begin : g_bad_phases
            $error("at least four sub-phases per pixel are required");
        end
        if (BLANK_START >= LINE_PIX) begin : g_bad_line
            $error("line has no blanking interval");
        end
    endgenerate

    logic [PH_W-1:0]  phase;
    logic [PIX_W-1:0] pix;
    logic             at_start;
    region_e          rgn;
    region_flags_t    flg;
    pix_strobe_t      strb;
    logic             vt;
    logic             drain;
    line_out_t        nxt;
    line_out_t        out_q;

    ccdh_counter #(
        .PHASES   (PHASES),
        .LINE_PIX (LINE_PIX)
    ) cnt_i (
        .clk      (clk),
        .rst      (rst),
        .phase    (phase),
        .pix      (pix),
        .at_start (at_start)
    );

    ccdh_region_dec #(
        .DUMMY_PIX (DUMMY_PIX),
        .OBF_PIX   (OBF_PIX),
        .ACT_PIX   (ACT_PIX),
        .OBR_PIX   (OBR_PIX),
        .PIX_W     (PIX_W)
    ) rgn_i (
        .pix (pix),
        .rgn (rgn),
        .flg (flg)
    );

    ccdh_pixel_strobes #(
        .PHASES (PHASES)
    ) strb_i (
        .phase (phase),
        .blank (flg.blank),
        .strb  (strb)
    );

    ccdh_blank_windows #(
        .BLANK_START (BLANK_START),
        .LINE_PIX    (LINE_PIX),
        .VT_OFS      (VT_OFS),
        .VT_PIX      (VT_PIX),
        .DRAIN_OFS   (DRAIN_OFS),
        .WIDTH_W     (WIDTH_W),
        .PIX_W       (PIX_W)
    ) win_i (
        .clk           (clk),
        .rst           (rst),
        .pix           (pix),
        .at_start      (at_start),
        .shutter_req   (shutter_req),
        .shutter_width (shutter_width),
        .vt            (vt),
        .drain         (drain)
    );

    always_comb begin
        nxt.line_start = at_start;
        nxt.strb       = strb;
        nxt.rgn        = rgn;
        nxt.flg        = flg;
        nxt.vt         = vt;
        nxt.drain      = drain;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= idle_out();
        else     out_q <= nxt;
    end

    assign line_start    = out_q.line_start;
    assign hclk_a        = out_q.strb.hclk_a;
    assign hclk_b        = out_q.strb.hclk_b;
    assign rst_gate      = out_q.strb.rst_gate;
    assign cds_ref       = out_q.strb.cds_ref;
    assign cds_sig       = out_q.strb.cds_sig;
    assign region        = out_q.rgn;
    assign is_dummy      = out_q.flg.dummy;
    assign is_ob         = out_q.flg.ob;
    assign is_active     = out_q.flg.active;
    assign is_blank      = out_q.flg.blank;
    assign vt_win        = out_q.vt;
    assign shutter_drain = out_q.drain;

endmodule

// File: rtl/ccdh_line_timing_chk.sv
module ccdh_line_timing_chk (
    input logic       clk,
    input logic       rst,
    input logic       line_start,
    input logic       hclk_a,
    input logic       hclk_b,
    input logic       rst_gate,
    input logic       cds_ref,
    input logic       cds_sig,
    input logic [2:0] region,
    input logic       is_dummy,
    input logic       is_ob,
    input logic       is_active,
    input logic       is_blank,
    input logic       vt_win,
    input logic       shutter_drain
);

    assert_hclk_compl_R3: assert property (@(posedge clk) disable iff (rst)
        hclk_a != hclk_b);

    assert_hclk_hold_blank_R3: assert property (@(posedge clk) disable iff (rst)
        is_blank |-> hclk_a);

    assert_gate_then_ref_R4: assert property (@(posedge clk) disable iff (rst)
        rst_gate |=> cds_ref);

    assert_gate_not_sig_R4: assert property (@(posedge clk) disable iff (rst)
        rst_gate |-> !cds_sig && !cds_ref);

    assert_strobe_quiet_blank_R4: assert property (@(posedge clk) disable iff (rst)
        is_blank |-> !rst_gate && !cds_ref && !cds_sig);

    assert_start_single_R1: assert property (@(posedge clk) disable iff (rst)
        line_start |=> !line_start);

    assert_start_in_dummy_R2: assert property (@(posedge clk) disable iff (rst)
        line_start |-> (region == 3'd0) && is_dummy);

    assert_flags_onehot_R2: assert property (@(posedge clk) disable iff (rst)
        $countones({is_dummy, is_ob, is_active, is_blank}) == 1);

    assert_vt_in_blank_R5: assert property (@(posedge clk) disable iff (rst)
        vt_win |-> is_blank);

    assert_drain_in_blank_R6: assert property (@(posedge clk) disable iff (rst)
        shutter_drain |-> is_blank && (region == 3'd4));

endmodule

bind ccdh_line_timing ccdh_line_timing_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .line_start    (line_start),
    .hclk_a        (hclk_a),
    .hclk_b        (hclk_b),
    .rst_gate      (rst_gate),
    .cds_ref       (cds_ref),
    .cds_sig       (cds_sig),
    .region        (region),
    .is_dummy      (is_dummy),
    .is_ob         (is_ob),
    .is_active     (is_active),
    .is_blank      (is_blank),
    .vt_win        (vt_win),
    .shutter_drain (shutter_drain)
);

// File: tb/ccdh_line_timing_tb_top.sv
`timescale 1ns/1ps
module ccdh_line_timing_tb_top;

    localparam int PH       = 4;
    localparam int LINE_PIX = 1848;
    localparam int TOT      = PH * LINE_PIX;
    localparam int B_OBF    = 28;
    localparam int B_ACT    = B_OBF + 4;
    localparam int B_OBR    = B_ACT + 1636;
    localparam int B_BLANK  = B_OBR + 48;
    localparam int VT_LO    = B_BLANK + 4;
    localparam int VT_HI    = VT_LO + 96;
    localparam int DR_LO    = B_BLANK + 108;
    localparam int WDOG     = 150000;

    typedef struct packed {
        logic       ls;
        logic       ha, hb, rg, cr, cs;
        logic [2:0] rgn;
        logic [3:0] flg;
        logic       vt, dr;
        logic       in_rst;
        logic       r7;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       shutter_req = 1'b0;
    logic [7:0] shutter_width = 8'd0;
    logic       line_start, hclk_a, hclk_b, rst_gate, cds_ref, cds_sig;
    logic [2:0] region;
    logic       is_dummy, is_ob, is_active, is_blank, vt_win, shutter_drain;

    int   n_checks = 0;
    int   n_errors = 0;
    int   mpos     = 0;
    int   mline    = 0;
    int   cycles   = 0;
    logic m_arm    = 1'b0;
    int   m_w      = 0;
    logic r7_mark  = 1'b0;
    exp_t q[$];

    always #2 clk = ~clk;

    ccdh_line_timing dut_i (
        .clk           (clk),
        .rst           (rst),
        .shutter_req   (shutter_req),
        .shutter_width (shutter_width),
        .line_start    (line_start),
        .hclk_a        (hclk_a),
        .hclk_b        (hclk_b),
        .rst_gate      (rst_gate),
        .cds_ref       (cds_ref),
        .cds_sig       (cds_sig),
        .region        (region),
        .is_dummy      (is_dummy),
        .is_ob         (is_ob),
        .is_active     (is_active),
        .is_blank      (is_blank),
        .vt_win        (vt_win),
        .shutter_drain (shutter_drain)
    );

    function automatic exp_t model(int pos, logic arm, int w, logic r7);
        exp_t e;
        int   pix = pos / PH;
        int   ph  = pos % PH;
        logic blk = (pix >= B_BLANK);
        e.ls  = (pos == 0);
        if (pix < B_OBF)        begin e.rgn = 3'd0; e.flg = 4'b1000; end
        else if (pix < B_ACT)   begin e.rgn = 3'd1; e.flg = 4'b0100; end
        else if (pix < B_OBR)   begin e.rgn = 3'd2; e.flg = 4'b0010; end
        else if (pix < B_BLANK) begin e.rgn = 3'd3; e.flg = 4'b0100; end
        else                    begin e.rgn = 3'd4; e.flg = 4'b0001; end
        e.ha  = blk ? 1'b1 : (ph < PH / 2);
        e.hb  = !e.ha;
        e.rg  = !blk && (ph == 0);
        e.cr  = !blk && (ph == 1);
        e.cs  = !blk && (ph == PH - 1);
        e.vt  = (pix >= VT_LO) && (pix < VT_HI);
        e.dr  = arm && (pix >= DR_LO) && (pix < DR_LO + w);
        e.in_rst = 1'b0;
        e.r7  = r7;
        return e;
    endfunction

    function automatic exp_t idle_item();
        exp_t e;
        e = '0;
        e.ha = 1'b1;
        e.rgn = 3'd4;
        e.flg = 4'b0001;
        e.in_rst = 1'b1;
        return e;
    endfunction

    // driver side of the scoreboard: one expected item per clock edge
    always @(posedge clk) begin
        cycles = cycles + 1;
        if (rst) begin
            q.push_back(idle_item());
            mpos  = 0;
            mline = 0;
            m_arm = 1'b0;
            m_w   = 0;
        end else begin
            if (mpos == 0) begin
                m_arm = shutter_req;
                m_w   = int'(shutter_width);
            end
            q.push_back(model(mpos, m_arm, m_w, r7_mark));
            mpos = mpos + 1;
            if (mpos == TOT) begin
                mpos  = 0;
                mline = mline + 1;
            end
        end
    end

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
        end
    endtask

    // monitor side: compare away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            if (e.in_rst) begin
                chk({line_start, hclk_a, hclk_b, rst_gate, cds_ref, cds_sig, vt_win, shutter_drain} ==
                    8'b0100_0000 && region == 3'd4 &&
                    {is_dummy, is_ob, is_active, is_blank} == 4'b0001,
                    "R8 idle outputs",
                    int'({line_start, hclk_a, hclk_b, rst_gate, cds_ref, cds_sig, region, is_blank}),
                    int'({8'b0100_0000, 3'd4, 1'b1}));
            end else begin
                chk(line_start == e.ls, "R1 line_start", int'(line_start), int'(e.ls));
                chk(region == e.rgn && {is_dummy, is_ob, is_active, is_blank} == e.flg,
                    "R2 region/flags",
                    int'({region, is_dummy, is_ob, is_active, is_blank}), int'({e.rgn, e.flg}));
                chk(hclk_a == e.ha && hclk_b == e.hb, "R3 shift clocks",
                    int'({hclk_a, hclk_b}), int'({e.ha, e.hb}));
                chk({rst_gate, cds_ref, cds_sig} == {e.rg, e.cr, e.cs}, "R4 gate/cds strobes",
                    int'({rst_gate, cds_ref, cds_sig}), int'({e.rg, e.cr, e.cs}));
                chk(vt_win == e.vt, "R5 vt window", int'(vt_win), int'(e.vt));
                if (e.r7)
                    chk(shutter_drain == e.dr, "R7 drain after late change", int'(shutter_drain), int'(e.dr));
                else
                    chk(shutter_drain == e.dr, "R6 drain pulse", int'(shutter_drain), int'(e.dr));
            end
        end
    end

    task automatic wait_at(input int ln, input int pix);
        while (!(mline == ln && mpos == pix * PH)) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > WDOG) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WDOG);
            finish_run();
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        // line 0: no drain; arm line 1 with width 10 (R6)
        wait_at(0, 100);
        shutter_req = 1'b1; shutter_width = 8'd10;
        // line 1: drop request after line start, pulse must survive (R7)
        wait_at(1, 5);
        shutter_req = 1'b0; shutter_width = 8'd2; r7_mark = 1'b1;
        // line 2: request low at its start -> no pulse; arm width 40 for line 3 (clip, R6)
        wait_at(2, 5);
        r7_mark = 1'b0;
        wait_at(2, 200);
        shutter_req = 1'b1; shutter_width = 8'd40;
        // line 4: width 0 with request high -> no pulse (R6)
        wait_at(3, 200);
        shutter_width = 8'd0;
        wait_at(4, 200);
        shutter_width = 8'd3;
        // line 5: reset during the drain pulse (R8)
        wait_at(5, DR_LO + 1);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        wait_at(1, 10);
        wait_at(2, 10);
        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule